// File: doc/BRIEF.md
# Six-Pin GPIO Port with Pin-Change Interrupts

This block is a small general-purpose I/O port for a microcontroller. Each of its pins is set up by the CPU through four internal registers: an output latch, a direction mask, an interrupt-enable option mask and a per-pin two-bit sensitivity field. A pin can be a plain input, an input that raises an interrupt request, or an output driven from its latch. One pin is wired as output-only and can never act as an input. A peripheral may take over any pin's output through an enable and data override.

Pin levels pass through a two-flop synchronizer. An extra sample of the synchronized level is then kept for edge detection. Each interrupt-capable pin has a request latch, and its sensitivity field picks which events set that latch. The latch clears when the CPU acknowledges that pin's vector, or when a write to the sensitivity register changes that pin's field.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, the latch, direction, option and sensitivity registers are zero and all interrupt requests are low. Every pin except the output-only pin has `pin_oe` low.
- R2: The register select `bus_addr` works as follows: 0 is the data register, 1 is direction, 2 is option, 3 is sensitivity. Pin i maps to bit i of the first three registers and to bits [2i+1:2i] of sensitivity. A write takes effect at the clock edge where `bus_we` is high. `bus_rdata` is combinational, and bits above a register's width read 0.
- R3: A pin whose direction bit is 1 has `pin_oe` high and drives its latch value on `pin_out`. A data-register read returns the latch value for that bit.
- R4: A pin whose direction bit is 0 has `pin_oe` low. A data-register read returns its synchronized level, which follows `pin_in` two clock edges after the change.
- R5: Writing the data register while a pin is an input changes only the latch, so `pin_oe` stays low. The new value appears on `pin_out` once the pin is switched to output.
- R6: Pin `OUT_ONLY_PIN` (default 3) always has `pin_oe` high. Its direction bit reads as 1 whatever was written, its data bit reads the latch, and it never raises a request.
- R7: A request can only be set on a pin whose direction bit is 0 and whose option bit is 1. A matching event is latched at the third clock edge after the `pin_in` change.
- R8: The sensitivity codes are: 00 means low level (which includes the falling edge), 01 means rising edge only, 10 means falling edge only, and 11 means both edges.
- R9: A one-cycle `irq_ack` pulse on pin i clears that pin's request at the next edge. The clear wins over an event in the same cycle, so a low level in mode 00 sets the request again one edge later.
- R10: A sensitivity write clears the pending request of every pin whose two-bit field changes. Pins whose field is rewritten with the same value keep their requests.
- R11: When `alt_en[i]` is high, `pin_oe[i]` is high and `pin_out[i]` follows `alt_dout[i]`, whatever the direction and latch are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register select |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 2*NPINS | Write data |
| bus_rdata | output | 2*NPINS | Read data for the selected register |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Pad output data |
| pin_oe | output | NPINS | Pad output enables |
| alt_en | input | NPINS | Peripheral output takeover per pin |
| alt_dout | input | NPINS | Peripheral output data |
| irq_ack | input | NPINS | Vector-fetch acknowledge pulse per pin |
| irq_req | output | NPINS | Pending interrupt requests |

## Verification
The bench uses the default parameters: six pins, pin 3 output-only, and a two-stage synchronizer. With these values the exact cycle at which a pin change shows up in a read and in a request can be checked. The fixed pin sits in the middle of the mask, so a shifted or mis-indexed output-only decode shows up in the output-enable and request patterns. The six pins are enough to run all four sensitivity codes at once, and to compare a pin whose field changes against one that is rewritten unchanged.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [1:0] {
        SENS_LOW   = 2'b00,
        SENS_RISE  = 2'b01,
        SENS_FALL  = 2'b10,
        SENS_BOTH  = 2'b11
    } sens_e;

    typedef enum logic [1:0] {
        SEL_DATA = 2'd0,
        SEL_DIR  = 2'd1,
        SEL_OPT  = 2'd2,
        SEL_SENS = 2'd3
    } reg_sel_e;

    function automatic logic sens_match(sens_e mode, logic now_lvl, logic was_lvl);
        logic hit;
        unique case (mode)
            SENS_LOW:  hit = ~now_lvl;
            SENS_RISE: hit = now_lvl & ~was_lvl;
            SENS_FALL: hit = ~now_lvl & was_lvl;
            default:   hit = now_lvl ^ was_lvl;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o,
    output logic [WIDTH-1:0] prev_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw_i;
        for (int k = 1; k < DEPTH; k++) begin
            chain_d[k] = chain_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign prev_o = chain_q[STAGES];
endmodule

// File: rtl/gpio_evt.sv
module gpio_evt
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 6
) (
    input  logic [NPINS-1:0]   lvl_i,
    input  logic [NPINS-1:0]   prev_i,
    input  logic [2*NPINS-1:0] sens_i,
    input  logic [NPINS-1:0]   en_i,
    output logic [NPINS-1:0]   evt_o
);
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign evt_o[i] = en_i[i] & sens_match(sens_e'(sens_i[2*i +: 2]), lvl_i[i], prev_i[i]);
    end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
    import gpio_irq_pkg::*;
#(
    parameter int NPINS        = 6,
    parameter int OUT_ONLY_PIN = 3,
    parameter int SYNC_STAGES  = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           bus_addr,
    input  logic                 bus_we,
    input  logic [2*NPINS-1:0]   bus_wdata,
    output logic [2*NPINS-1:0]   bus_rdata,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pin_out,
    output logic [NPINS-1:0]     pin_oe,
    input  logic [NPINS-1:0]     alt_en,
    input  logic [NPINS-1:0]     alt_dout,
    input  logic [NPINS-1:0]     irq_ack,
    output logic [NPINS-1:0]     irq_req
);
    localparam int RW = 2 * NPINS;
    localparam logic [NPINS-1:0] FIXED_OUT = NPINS'(1) << OUT_ONLY_PIN;

    typedef struct packed {
        logic [NPINS-1:0] data;
        logic [NPINS-1:0] dir;
        logic [NPINS-1:0] opt;
        logic [NPINS-1:0] req;
        logic [RW-1:0]    sens;
    } regs_t;

    regs_t st_d, st_q;

    logic [NPINS-1:0] lvl, lvl_prev, eff_dir, int_en, evt, sens_chg;
    logic [NPINS-1:0] dir_q, opt_q;
    logic [RW-1:0]    sens_q;
    logic             wr_sens;

    gpio_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (lvl),
        .prev_o (lvl_prev)
    );

    assign eff_dir = st_q.dir | FIXED_OUT;
    assign int_en  = ~eff_dir & st_q.opt;

    gpio_evt #(.NPINS(NPINS)) u_evt (
        .lvl_i  (lvl),
        .prev_i (lvl_prev),
        .sens_i (st_q.sens),
        .en_i   (int_en),
        .evt_o  (evt)
    );

    assign wr_sens = bus_we && (reg_sel_e'(bus_addr) == SEL_SENS);

    for (genvar i = 0; i < NPINS; i++) begin : g_chg
        assign sens_chg[i] = wr_sens && (bus_wdata[2*i +: 2] != st_q.sens[2*i +: 2]);
    end

    always_comb begin
        st_d = st_q;
        if (bus_we) begin
            unique case (reg_sel_e'(bus_addr))
                SEL_DATA: st_d.data = bus_wdata[NPINS-1:0];
                SEL_DIR:  st_d.dir  = bus_wdata[NPINS-1:0];
                SEL_OPT:  st_d.opt  = bus_wdata[NPINS-1:0];
                default:  st_d.sens = bus_wdata;
            endcase
        end
        // clears take priority over a same-cycle event
        st_d.req = (st_q.req | evt) & ~irq_ack & ~sens_chg & ~FIXED_OUT;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            SEL_DATA: bus_rdata = RW'((eff_dir & st_q.data) | (~eff_dir & lvl));
            SEL_DIR:  bus_rdata = RW'(eff_dir);
            SEL_OPT:  bus_rdata = RW'(st_q.opt);
            default:  bus_rdata = st_q.sens;
        endcase
    end

    assign pin_oe  = eff_dir | alt_en;
    assign pin_out = (alt_en & alt_dout) | (~alt_en & st_q.data);
    assign irq_req = st_q.req;

    assign dir_q  = st_q.dir;
    assign opt_q  = st_q.opt;
    assign sens_q = st_q.sens;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk #(
    parameter int NPINS        = 6,
    parameter int OUT_ONLY_PIN = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           bus_addr,
    input logic                 bus_we,
    input logic [2*NPINS-1:0]   bus_wdata,
    input logic [2*NPINS-1:0]   sens_q,
    input logic [NPINS-1:0]     dir_q,
    input logic [NPINS-1:0]     opt_q,
    input logic [NPINS-1:0]     irq_ack,
    input logic [NPINS-1:0]     irq_req,
    input logic [NPINS-1:0]     pin_oe
);
    logic [NPINS-1:0] field_moved;

    for (genvar i = 0; i < NPINS; i++) begin : g_mv
        assign field_moved[i] = bus_wdata[2*i +: 2] != sens_q[2*i +: 2];
    end

    // R9: acknowledge clears the request at the next edge
    a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack != '0) |=> ((irq_req & $past(irq_ack)) == '0));

    // R10: a changed sensitivity field drops that pin's request
    a_r10_sens_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == 2'd3) |=> ((irq_req & $past(field_moved)) == '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_cfg
        if (i == OUT_ONLY_PIN) begin : g_fixed
            // R6: output-only pin drives and never requests
            a_r6_fixed_drives: assert property (@(posedge clk) disable iff (!rst_n)
                pin_oe[i]);
            a_r6_fixed_no_req: assert property (@(posedge clk) disable iff (!rst_n)
                !irq_req[i]);
        end else begin : g_norm
            // R7: a request only appears on an interrupt-enabled input
            a_r7_req_needs_intin: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(irq_req[i]) |-> $past(!dir_q[i] && opt_q[i]));
        end
    end
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .OUT_ONLY_PIN(OUT_ONLY_PIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .sens_q    (sens_q),
    .dir_q     (dir_q),
    .opt_q     (opt_q),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .pin_oe    (pin_oe)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
    localparam int N  = 6;
    localparam int RW = 2 * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [RW-1:0] bus_wdata = '0;
    logic [RW-1:0] bus_rdata;
    logic [N-1:0]  pin_in = '0, pin_out, pin_oe;
    logic [N-1:0]  alt_en = '0, alt_dout = '0, irq_ack = '0, irq_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_port #(.NPINS(N), .OUT_ONLY_PIN(3), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .alt_en(alt_en), .alt_dout(alt_dout),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_neg(int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pin_in = '0; alt_en = '0; alt_dout = '0; irq_ack = '0; bus_we = 1'b0;
        wait_neg(3);
        rst_n = 1'b1;
        wait_neg(1);
    endtask

    task automatic wr(logic [1:0] a, logic [RW-1:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [RW-1:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [RW-1:0] v;
        do_reset();
        rd(2'd0, v); check("R1 data", v, 0);
        rd(2'd1, v); check("R1/R6 dir", v, 12'h008);
        rd(2'd2, v); check("R1 opt", v, 0);
        rd(2'd3, v); check("R1 sens", v, 0);
        check("R1 req", irq_req, 0);
        check("R1 oe", pin_oe, 6'h08);
    endtask

    task automatic t_output_input();
        logic [RW-1:0] v;
        do_reset();
        wr(2'd1, 12'h007);
        wr(2'd0, 12'h005);
        #1 check("R3 oe", pin_oe, 6'b001111);
        check("R3 pin_out", pin_out[2:0], 3'b101);
        rd(2'd0, v); check("R3 data read latch", v, 12'h005);
        wr(2'd2, 12'hFC0);
        rd(2'd2, v); check("R2 opt width", v, 12'h000);
        pin_in = 6'b110000;
        wait_neg(1);
        rd(2'd0, v); check("R4 one edge not yet", v, 12'h005);
        wait_neg(1);
        rd(2'd0, v); check("R4 synced read", v, 12'h035);
    endtask

    task automatic t_write_while_input();
        logic [RW-1:0] v;
        do_reset();
        pin_in = 6'b110000;
        wait_neg(3);
        wr(2'd0, 12'h00A);
        #1 check("R5 oe unchanged", pin_oe, 6'h08);
        rd(2'd0, v); check("R5 read pins", v, 12'h038);
        wr(2'd1, 12'h002);
        #1 check("R5 oe after dir", pin_oe, 6'b001010);
        check("R5 latch driven", pin_out[1], 1'b1);
    endtask

    task automatic t_fixed_pin();
        logic [RW-1:0] v;
        do_reset();
        wr(2'd0, 12'h008);
        wr(2'd1, 12'h000);
        wr(2'd3, 12'hFFF);
        wr(2'd2, 12'h03F);
        rd(2'd1, v); check("R6 dir reads one", v, 12'h008);
        rd(2'd0, v); check("R6 data reads latch", v, 12'h008);
        check("R6 oe", pin_oe[3], 1'b1);
        pin_in[3] = 1'b1;
        wait_neg(4);
        pin_in[3] = 1'b0;
        wait_neg(4);
        check("R6 no request", irq_req, 0);
    endtask

    task automatic t_enable();
        do_reset();
        wr(2'd3, 12'h555);
        pin_in[0] = 1'b1;
        wait_neg(4);
        check("R7 option off", irq_req, 0);
        wr(2'd1, 12'h001);
        wr(2'd2, 12'h001);
        pin_in[0] = 1'b0; wait_neg(4);
        pin_in[0] = 1'b1; wait_neg(4);
        check("R7 output no request", irq_req, 0);
        wr(2'd1, 12'h000);
        pin_in[0] = 1'b0; wait_neg(4);
        pin_in[0] = 1'b1;
        wait_neg(2);
        check("R7 not before third edge", irq_req, 0);
        wait_neg(1);
        check("R7 third edge", irq_req, 6'h01);
    endtask

    task automatic t_modes();
        do_reset();
        // pin0 rise, pin1 fall, pin2 both, pin4 low, pin5 rise
        wr(2'd3, {2'b01, 2'b00, 2'b00, 2'b11, 2'b10, 2'b01});
        wr(2'd2, 12'h037);
        wait_neg(1);
        check("R8 low level", irq_req, 6'b010000);
        pin_in = 6'b000111;
        wait_neg(3);
        check("R8 rising set", irq_req, 6'b010101);
        irq_ack = 6'h3F;
        wait_neg(1);
        irq_ack = '0;
        check("R9 ack clears", irq_req, 0);
        wait_neg(1);
        check("R9 level re-sets", irq_req, 6'b010000);
        pin_in = 6'b000000;
        wait_neg(3);
        check("R8 falling set", irq_req, 6'b010110);
    endtask

    task automatic t_sens_clear();
        do_reset();
        wr(2'd3, 12'h555);
        wr(2'd2, 12'h003);
        pin_in = 6'b000011;
        wait_neg(4);
        check("R10 both pending", irq_req, 6'b000011);
        wr(2'd3, 12'h556);
        check("R10 changed field clears", irq_req, 6'b000010);
        wr(2'd3, 12'h556);
        check("R10 same value keeps", irq_req, 6'b000010);
    endtask

    task automatic t_alt();
        do_reset();
        alt_en = 6'b000010; alt_dout = 6'b000010;
        #1 check("R11 oe", pin_oe, 6'b001010);
        check("R11 data", pin_out[1], 1'b1);
        alt_dout = '0;
        #1 check("R11 follows", pin_out[1], 1'b0);
    endtask

    initial begin
        t_reset();
        t_output_input();
        t_write_while_input();
        t_fixed_pin();
        t_enable();
        t_modes();
        t_sens_clear();
        t_alt();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule